// File: doc/BRIEF.md
# Retentive Set/Reset Memory Bit

This block stores one bit that two separate control inputs drive: one sets it and one clears it. It gives the stored value and its complement. An elaboration-time parameter chooses which control wins when both are asserted. One module therefore serves both the clear-dominant and the set-dominant form. Set and clear act only on clock edges where the execution-cycle enable is high, so the bit follows the update rate of the surrounding logic scheduler.

A second parameter chooses what happens across a power interruption. The interruption is modelled as a handshake. A `power_fail` pulse copies the live bit into a shadow register and parks the block in a powered-down state, where the outputs read cleared and set/clear have no effect. A later `restore` pulse brings the block back to running. With retention on, the bit comes back with its captured value. With retention off, it always comes back cleared. The synchronous reset `rst` clears everything and overrides both parameters.

The controller is a three-state machine. Its states are **LATCH_CLEAR** (running, bit 0), **LATCH_SET** (running, bit 1) and **POWER_DOWN** (parked). Its transitions are:
- **update**: a running state moves to the other running state, on an enabled edge where the resolved set/clear demands it.
- **suspend**: a running state moves to POWER_DOWN on `power_fail`.
- **resume**: POWER_DOWN moves to LATCH_SET or LATCH_CLEAR on `restore`.
- **wipe**: any state moves to LATCH_CLEAR on `rst`.

Top module: `srl_retentive`

## Requirements
- R1: One clock edge after `rst` is sampled high, the block is running with `q`=0 and `q_n`=1. The shadow copy is also cleared.
- R2: `q_n` is always the logical inverse of `q`.
- R3: While running, with `exec_en`=1, `set_in`=1 and `clr_in`=0, `q` is 1 after the next edge.
- R4: While running, with `exec_en`=1, `clr_in`=1 and `set_in`=0, `q` is 0 after the next edge.
- R5: While running, with `exec_en`=1 and neither control asserted, `q` keeps its value.
- R6: While running, with `exec_en`=1 and both controls asserted, `q` becomes 0 when `PRIORITY_SET`=0 and becomes 1 when `PRIORITY_SET`=1.
- R7: While running, with `exec_en`=0 and no `power_fail`, `q` keeps its value whatever `set_in` and `clr_in` are.
- R8: A `power_fail` pulse while running captures `q` into the shadow copy and enters POWER_DOWN, independent of `exec_en`. In that state `q`=0, and `set_in`, `clr_in` and repeated `power_fail` pulses have no effect. Within a running cycle, `power_fail` takes priority over set/clear.
- R9: With `RETAIN`=1, a `restore` pulse in POWER_DOWN returns to running with `q` equal to the value captured at the last `power_fail`.
- R10: With `RETAIN`=0, a `restore` pulse in POWER_DOWN returns to running with `q`=0, whatever was captured.
- R11: A `restore` pulse while running has no effect on `q`.
- R12: `rst` overrides every other input and every state, including POWER_DOWN. A `restore` after such a reset finds the block running and leaves `q`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| exec_en | input | 1 | Execution-cycle enable for set/clear updates |
| set_in | input | 1 | Set request |
| clr_in | input | 1 | Clear request |
| power_fail | input | 1 | Power-interruption pulse: capture and park |
| restore | input | 1 | Power-return pulse: resume from park |
| q | output | 1 | Stored bit |
| q_n | output | 1 | Inverse of the stored bit |

## Verification
The bound checker enforces the following on every cycle:
- the set, clear, both-asserted and disabled-enable updates;
- that `q` is forced low while parked;
- that a suspend captures the live bit;
- that a resume loads the captured bit or zero, according to the retention setting;
- that reset returns the block to a cleared running state.

The bench's scenarios, run on all four combinations of priority and retention against a behavioural model, show the effects that need a history behind them:
- the inverse output;
- that a restore while running is ignored;
- that set/clear during POWER_DOWN leave no trace once the block resumes;
- that a capture of 0 and a capture of 1 each survive a round trip.

// File: rtl/srl_pkg.sv
package srl_pkg;

    typedef enum logic [1:0] {
        LATCH_CLEAR = 2'd0,
        LATCH_SET   = 2'd1,
        POWER_DOWN  = 2'd2
    } srl_state_e;

endpackage

// File: rtl/srl_priority.sv
// Resolves the set/clear request pair into the next stored bit.
module srl_priority #(
    parameter int PRIORITY_SET = 0
) (
    input  logic set_in,
    input  logic clr_in,
    input  logic cur_bit,
    output logic nxt_bit
);
    generate
        if (PRIORITY_SET != 0) begin : g_set_wins
            always_comb begin
                if (set_in)      nxt_bit = 1'b1;
                else if (clr_in) nxt_bit = 1'b0;
                else             nxt_bit = cur_bit;
            end
        end else begin : g_clr_wins
            always_comb begin
                if (clr_in)      nxt_bit = 1'b0;
                else if (set_in) nxt_bit = 1'b1;
                else             nxt_bit = cur_bit;
            end
        end
    endgenerate
endmodule

// File: rtl/srl_shadow.sv
// Shadow copy written at suspend; returns zero when retention is off.
module srl_shadow #(
    parameter int RETAIN = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic capture,
    input  logic din,
    output logic dout
);
    localparam logic KEEP = (RETAIN != 0);

    logic held;

    always_ff @(posedge clk) begin
        if (rst)          held <= 1'b0;
        else if (capture) held <= din & KEEP;
    end

    assign dout = held;
endmodule

// File: rtl/srl_retentive.sv
module srl_retentive
    import srl_pkg::*;
#(
    parameter int PRIORITY_SET = 0,
    parameter int RETAIN       = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic exec_en,
    input  logic set_in,
    input  logic clr_in,
    input  logic power_fail,
    input  logic restore,
    output logic q,
    output logic q_n
);
    srl_state_e st, st_nxt;
    logic       live_bit;
    logic       resolved_bit;
    logic       st_down;
    logic       capture;
    logic       shadow_bit;

    assign live_bit = (st == LATCH_SET);
    assign st_down  = (st == POWER_DOWN);
    assign capture  = !st_down && power_fail;

    srl_priority #(.PRIORITY_SET(PRIORITY_SET)) prio_i (
        .set_in (set_in),
        .clr_in (clr_in),
        .cur_bit(live_bit),
        .nxt_bit(resolved_bit)
    );

    srl_shadow #(.RETAIN(RETAIN)) shadow_i (
        .clk    (clk),
        .rst    (rst),
        .capture(capture),
        .din    (live_bit),
        .dout   (shadow_bit)
    );

    // next-state logic
    always_comb begin
        st_nxt = st;
        unique case (st)
            LATCH_CLEAR, LATCH_SET: begin
                if (power_fail)   st_nxt = POWER_DOWN;
                else if (exec_en) st_nxt = resolved_bit ? LATCH_SET : LATCH_CLEAR;
            end
            POWER_DOWN: begin
                if (restore) st_nxt = shadow_bit ? LATCH_SET : LATCH_CLEAR;
            end
            default: st_nxt = LATCH_CLEAR;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) st <= LATCH_CLEAR;
        else     st <= st_nxt;
    end

    // outputs
    always_comb begin
        unique case (st)
            LATCH_SET: q = 1'b1;
            default:   q = 1'b0;
        endcase
        q_n = ~q;
    end
endmodule

// File: rtl/srl_retentive_chk.sv
module srl_retentive_chk #(
    parameter int PRIORITY_SET = 0,
    parameter int RETAIN       = 1
) (
    input logic clk,
    input logic rst,
    input logic exec_en,
    input logic set_in,
    input logic clr_in,
    input logic power_fail,
    input logic restore,
    input logic q,
    input logic down,
    input logic shadow
);
    localparam logic WIN  = (PRIORITY_SET != 0);
    localparam logic KEEP = (RETAIN != 0);

    p_reset_r1: assert property (@(posedge clk)
        rst |=> (!q && !down && !shadow));

    p_set_r3: assert property (@(posedge clk) disable iff (rst)
        (!down && !power_fail && exec_en && set_in && !clr_in) |=> q);

    p_clear_r4: assert property (@(posedge clk) disable iff (rst)
        (!down && !power_fail && exec_en && clr_in && !set_in) |=> !q);

    p_both_r6: assert property (@(posedge clk) disable iff (rst)
        (!down && !power_fail && exec_en && set_in && clr_in) |=> (q == WIN));

    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (!down && !power_fail && !exec_en) |=> $stable(q));

    p_parked_low_r8: assert property (@(posedge clk) disable iff (rst)
        down |-> !q);

    p_capture_r8: assert property (@(posedge clk) disable iff (rst)
        (!down && power_fail) |=> (down && shadow == ($past(q) & KEEP)));

    p_resume_r9: assert property (@(posedge clk) disable iff (rst)
        (down && restore) |=> (!down && q == ($past(shadow) & KEEP)));
endmodule

bind srl_retentive srl_retentive_chk #(
    .PRIORITY_SET(PRIORITY_SET),
    .RETAIN      (RETAIN)
) chk_i (
    .clk       (clk),
    .rst       (rst),
    .exec_en   (exec_en),
    .set_in    (set_in),
    .clr_in    (clr_in),
    .power_fail(power_fail),
    .restore   (restore),
    .q         (q),
    .down      (st_down),
    .shadow    (shadow_bit)
);

// File: tb/srl_retentive_tb_top.sv
`timescale 1ns/1ps
module srl_retentive_tb_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic exec_en = 1'b0, set_in = 1'b0, clr_in = 1'b0;
    logic power_fail = 1'b0, restore = 1'b0;
    logic [3:0] q_o, qn_o;

    int n_checks = 0;
    int n_fail   = 0;
    string tag = "R1";
    bit done = 1'b0;

    always #5 clk = ~clk;

    // variant k: priority = k%2, retain = (k<2)
    for (genvar k = 0; k < 4; k++) begin : g
        srl_retentive #(.PRIORITY_SET(k % 2), .RETAIN(k < 2 ? 1 : 0)) dut_i (
            .clk(clk), .rst(rst), .exec_en(exec_en), .set_in(set_in), .clr_in(clr_in),
            .power_fail(power_fail), .restore(restore), .q(q_o[k]), .q_n(qn_o[k])
        );
    end

    // behavioural reference
    bit m_q[4], m_down[4], m_sh[4];

    task automatic check(string t, int k, bit act, bit exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s variant %0d: actual %0b expected %0b", t, k, act, exp);
        end
    endtask

    always @(posedge clk) begin
        for (int k = 0; k < 4; k++) begin
            if (rst) begin
                m_q[k] = 0; m_down[k] = 0; m_sh[k] = 0;
            end else if (!m_down[k]) begin
                if (power_fail) begin
                    m_sh[k] = m_q[k]; m_down[k] = 1;
                end else if (exec_en) begin
                    if (set_in && clr_in) m_q[k] = (k % 2 == 1);
                    else if (set_in)      m_q[k] = 1;
                    else if (clr_in)      m_q[k] = 0;
                end
            end else if (restore) begin
                m_q[k] = (k < 2) ? m_sh[k] : 1'b0;
                m_down[k] = 0;
            end
        end
        #2;
        for (int k = 0; k < 4; k++) begin
            check(tag, k, q_o[k], m_down[k] ? 1'b0 : m_q[k]);
            check("R2", k, qn_o[k], ~q_o[k]);
        end
    end

    task automatic step(string t, bit r, bit en, bit s, bit c, bit pf, bit rs);
        @(negedge clk);
        tag = t; rst = r; exec_en = en; set_in = s; clr_in = c;
        power_fail = pf; restore = rs;
    endtask

    initial begin
        step("R1", 1, 0, 0, 0, 0, 0);
        step("R1", 1, 1, 1, 0, 0, 0);
        step("R5", 0, 1, 0, 0, 0, 0);
        step("R3", 0, 1, 1, 0, 0, 0);
        step("R5", 0, 1, 0, 0, 0, 0);
        step("R4", 0, 1, 0, 1, 0, 0);
        step("R6", 0, 1, 1, 1, 0, 0);   // both from 0
        step("R3", 0, 1, 1, 0, 0, 0);
        step("R6", 0, 1, 1, 1, 0, 0);   // both from 1 (clear-dominant drops)
        step("R6", 0, 1, 1, 1, 0, 0);
        step("R4", 0, 1, 0, 1, 0, 0);
        step("R7", 0, 0, 1, 0, 0, 0);
        step("R7", 0, 0, 1, 1, 0, 0);
        step("R3", 0, 1, 1, 0, 0, 0);
        step("R7", 0, 0, 0, 1, 0, 0);
        step("R11", 0, 1, 0, 0, 0, 1);
        step("R8", 0, 0, 0, 1, 1, 0);   // suspend with q=1, pf beats clear
        step("R8", 0, 1, 0, 1, 0, 0);
        step("R8", 0, 1, 1, 0, 1, 0);
        step("R8", 0, 1, 1, 1, 0, 0);
        step("R9", 0, 0, 0, 0, 0, 1);   // resume: retain gives 1, else 0
        step("R10", 0, 1, 0, 0, 0, 0);
        step("R4", 0, 1, 0, 1, 0, 0);
        step("R8", 0, 1, 1, 0, 1, 0);   // capture 0
        step("R8", 0, 1, 1, 0, 0, 0);
        step("R10", 0, 0, 0, 0, 0, 1);
        step("R3", 0, 1, 1, 0, 0, 0);
        step("R8", 0, 0, 0, 0, 1, 0);
        step("R12", 1, 1, 1, 0, 0, 1);  // reset while parked
        step("R12", 0, 0, 0, 0, 0, 1);
        step("R12", 0, 0, 0, 0, 0, 0);
        step("R5", 0, 1, 0, 0, 0, 0);
        @(negedge clk);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                #100000;
                n_checks++; n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule